// File: doc/BRIEF.md
# Two-Level Leading One Detector

This block takes a 16-bit word and reports where its most significant set bit sits. The position is given as a 4-bit index counted down from the top bit. A separate flag says that the word holds no set bit at all. Typical users are normalisation and priority stages that need a short, predictable path from a wide word to a small index.

The word is cut into four contiguous 4-bit groups. Every group finds, on its own and at the same time as the others, two things: whether it holds a one, and the offset of its highest one from the group's top bit. A second level takes the highest group that holds a one and puts that group's number in front of its local offset. This works the way carry-lookahead works. It replaces one wide priority encoder that would have to look at all sixteen bits at once.

The result can be taken straight from the logic or passed through one output register, chosen by a parameter. By default the register is present.

Top module: `lead_one_det`

## Requirements
- R1: For a non-zero word, `pos_o` equals 15 minus the bit number of the highest set bit. A word whose top set bit is bit 15 gives 0, and a word whose top set bit is bit 0 gives 15.
- R2: Bits below the highest set bit have no effect on `pos_o` or `zero_o`.
- R3: `zero_o` is 1 exactly when all 16 input bits are 0.
- R4: While `zero_o` is 1, `pos_o` is 0.
- R5: `pos_o[3:2]` names the highest group holding a one. Group 0 is bits 15..12, group 1 is bits 11..8, group 2 is bits 7..4 and group 3 is bits 3..0. `pos_o[1:0]` is the offset of the leading one below that group's top bit.
- R6: With the default output register, the outputs show the result for the word sampled at the previous rising edge of `clk`. While `rst_n` is low, `zero_o` is 1 and `pos_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| word_i | input | 16 | Word to scan |
| pos_o | output | 4 | Index of the leading one, counted from the top bit |
| zero_o | output | 1 | High when the word has no set bit |

## Verification
The detector is driven with every one of the 65536 words. This covers the all-zero word and every single-bit word, which separate the index arithmetic from the zero flag. It also covers words that share a top bit but differ below it, which show that lower bits are ignored. Words whose only ones lie in one group, or on a group's top or bottom bit, show whether the group selection and the local offset are joined in the right order. A short directed run before the full sweep alternates extreme words back to back. This shows the one-cycle latency and that no result from one word carries over into the next.

// File: rtl/lead_one_det.sv
module lead_one_det #(
  parameter int WIDTH   = 16,
  parameter int GROUP   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [WIDTH-1:0]                              word_i,
  output logic [$clog2(WIDTH/GROUP)+$clog2(GROUP)-1:0]  pos_o,
  output logic                                          zero_o
);
  localparam int NGRP = WIDTH / GROUP;
  localparam int LW   = $clog2(GROUP);
  localparam int GW   = $clog2(NGRP);
  localparam int PW   = GW + LW;

  logic [NGRP-1:0] grp_hit;
  logic [LW-1:0]   grp_off [NGRP];
  logic [PW-1:0]   pos_c;
  logic            zero_c;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GROUP-1:0] slice;
    assign slice      = word_i[WIDTH-1-g*GROUP -: GROUP];
    assign grp_hit[g] = |slice;
    always_comb begin
      grp_off[g] = '0;
      for (int k = 0; k < GROUP; k++)
        if (slice[k]) grp_off[g] = LW'(GROUP - 1 - k);
    end
  end

  always_comb begin
    pos_c = '0;
    for (int g = NGRP - 1; g >= 0; g--)
      if (grp_hit[g]) pos_c = {GW'(g), grp_off[g]};
  end

  assign zero_c = ~|grp_hit;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_o  <= '0;
        zero_o <= 1'b1;
      end else begin
        pos_o  <= pos_c;
        zero_o <= zero_c;
      end
    end
  end else begin : g_comb
    assign pos_o  = pos_c;
    assign zero_o = zero_c;
  end
endmodule

// File: rtl/lead_one_det_chk.sv
module lead_one_det_chk #(
  parameter int WIDTH   = 16,
  parameter int PW      = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] word_i,
  input logic [PW-1:0]    pos_o,
  input logic             zero_o
);
  logic [WIDTH-1:0] w_seen;
  if (OUT_REG) begin : g_d
    always_ff @(posedge clk) w_seen <= word_i;
  end else begin : g_nd
    assign w_seen = word_i;
  end

  AST_ZERO_POS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> pos_o == '0); // R4
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (zero_o && pos_o == '0)); // R6
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (zero_o == (w_seen == '0))); // R3
  AST_LEAD_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !zero_o) |-> w_seen[WIDTH-1-int'(pos_o)]); // R1
  AST_ABOVE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !zero_o && pos_o != '0) |->
      ((w_seen >> (WIDTH - int'(pos_o))) == '0)); // R2
endmodule

bind lead_one_det lead_one_det_chk #(
  .WIDTH(WIDTH), .PW(PW), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word_i(word_i), .pos_o(pos_o), .zero_o(zero_o)
);

// File: tb/lead_one_det_test.sv
module lead_one_det_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word_i = '0;
  logic [3:0]  pos_o;
  logic        zero_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] pend [$];

  always #2.5 clk = ~clk;

  lead_one_det uut (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .pos_o(pos_o), .zero_o(zero_o)
  );

  function automatic int ref_pos(input logic [15:0] w);
    int p = 0;
    for (int b = 0; b < 16; b++) if (w[b]) p = 15 - b;
    return p;
  endfunction

  function automatic int ref_grp(input logic [15:0] w);
    for (int g = 0; g < 4; g++) if (w[15-4*g -: 4] != 0) return g;
    return 0;
  endfunction

  task automatic compare(input logic [15:0] w, input string tag);
    checks++;
    if (zero_o !== (w == 0)) begin
      fails++;
      $display("FAIL R3 %s word=%h zero_o=%b expected %b", tag, w, zero_o, (w == 0));
    end
    checks++;
    if (w == 0) begin
      if (pos_o !== 4'd0) begin
        fails++;
        $display("FAIL R4 %s pos_o=%0d expected 0", tag, pos_o);
      end
    end else if (int'(pos_o) != ref_pos(w)) begin
      fails++;
      $display("FAIL R1 %s word=%h pos_o=%0d expected %0d", tag, w, pos_o, ref_pos(w));
    end
    checks++;
    if (w != 0 && int'(pos_o[3:2]) != ref_grp(w)) begin
      fails++;
      $display("FAIL R5 %s word=%h group=%0d expected %0d", tag, w, pos_o[3:2], ref_grp(w));
    end
  endtask

  task automatic step(input logic [15:0] w, input string tag);
    @(negedge clk);
    if (pend.size() != 0) compare(pend.pop_front(), tag);
    pend.push_back(w);
    word_i = w;
  endtask

  initial begin
    word_i = 16'hFFFF;
    repeat (3) @(negedge clk);
    checks++;
    if (zero_o !== 1'b1 || pos_o !== 4'd0) begin
      fails++;
      $display("FAIL R6 reset zero_o=%b pos_o=%0d expected 1 0", zero_o, pos_o);
    end
    rst_n = 1'b1;
    pend.delete();
    // R6 back-to-back extremes, R2 same top bit with different tails
    step(16'h0001, "R6");
    step(16'h8000, "R6");
    step(16'h0000, "R6");
    step(16'hFFFF, "R2");
    step(16'h8001, "R2");
    step(16'h0100, "R5");
    step(16'h01FF, "R2");
    step(16'h0008, "R5");
    step(16'h1000, "R5");
    for (int i = 0; i < 65536; i++) step(16'(i), "sweep");
    step(16'h0000, "drain");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired checks=%0d expected completion", checks);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule